// File: doc/BRIEF.md
# RC6 Encryption Round Engine

This block encrypts one 128-bit block at a time with the RC6 cipher, using a single shared round datapath that is reused for all twenty rounds. The block is held in four 32-bit working words A, B, C and D. Only the encryption direction is built. Round keys are not generated here: a table of 44 precomputed key words sits outside the block and is read through an indexed port that returns one pair of words per cycle.

Each round takes two clock cycles. The first cycle forms the two quadratic mixing terms from B and D. The second cycle applies the XOR, the data-dependent rotations and the key addition to A and C, and then rotates the four words by one position. Input whitening is folded into the cycle that accepts the start pulse. Output whitening takes one final cycle. The result stays on the output until the next block is accepted.

A host drives a plaintext and pulses `start` while the engine is idle. It serves key pairs for whatever index the engine presents, and collects the ciphertext when `done` pulses.

Top module: `rc6_enc_core`

## Requirements
- R1: While reset is held, `done` is 0, `key_idx` is 0 and `result` is all zeros.
- R2: Word A is taken from `block_in[31:0]`, B from `[63:32]`, C from `[95:64]` and D from `[127:96]`. Within each word, byte 0 of the word's slice is the least significant byte. `result` uses the same packing.
- R3: Key index j addresses the pair {S[2j+1], S[2j]}. S[2j] is in `key_pair[31:0]` and S[2j+1] is in `key_pair[63:32]`. The pair is consumed in the same cycle its index is shown.
- R4: When `start` is accepted, A and C load unchanged, B loads as the plaintext B plus S[0], and D loads as the plaintext D plus S[1] (all modulo 2^32).
- R5: In the first cycle of round i, the engine forms t = rotl(B·(2B+1) mod 2^32, 5) and u = rotl(D·(2D+1) mod 2^32, 5).
- R6: In the second cycle of round i, A' = rotl(A xor t, u[4:0]) + S[2i] and C' = rotl(C xor u, t[4:0]) + S[2i+1]. Then (A,B,C,D) becomes (B, C', D, A').
- R7: After round 20, A gains S[42] and C gains S[43]. B and D are unchanged by this step.
- R8: If `start` is sampled at a rising edge, `done` is high for exactly one cycle after the 41st rising edge that follows it, which is 42 cycles after the start cycle.
- R9: A `start` pulse that arrives while an encryption is in progress is ignored. The running block completes with its original result and on its original schedule.
- R10: While idle and not started, `result` holds its value, whatever `block_in` does.
- R11: `key_idx` shows 0 while idle. It shows i during both cycles of round i and 21 during the output whitening cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin encrypting `block_in` (accepted only when idle) |
| block_in | input | 128 | Plaintext, four little-endian words |
| key_idx | output | 5 | Index of the key pair wanted this cycle |
| key_pair | input | 64 | Key words {S[2j+1], S[2j]} for the shown index |
| result | output | 128 | Working words / ciphertext, same packing as the input |
| done | output | 1 | One-cycle pulse: `result` holds the ciphertext |

## Verification
The assertions assume that the key table answers within the same cycle and never changes the pair for an index while the engine is using it. They also assume that `start` is low during reset. The bench serves `key_pair` combinationally from a fixed array and rewrites the table only between encryptions. It keeps `start` low until reset is released, and it changes its inputs only on the falling edge. Stray start pulses and changes to `block_in` are applied only where the requirements say they must have no effect.

// File: rtl/rc6_pkg.sv
package rc6_pkg;

    // Sequencer phases of the round engine
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // waiting for start; key index parked at 0
        ST_MIX  = 2'd1,  // first half of a round: quadratic terms
        ST_ROT  = 2'd2,  // second half: rotate, add key, shift words
        ST_FIN  = 2'd3   // output whitening
    } rc6_state_e;

endpackage

// File: rtl/rc6_quad_mix.sv
// y = rotl(x * (2x + 1) mod 2^W, log2(W))
module rc6_quad_mix #(
    parameter int WORD_W = 32,
    parameter int LG_W   = 5
) (
    input  logic [WORD_W-1:0] x_i,
    output logic [WORD_W-1:0] y_o
);
    logic [WORD_W-1:0] odd_w;
    logic [WORD_W-1:0] prod_w;

    always_comb begin
        odd_w  = {x_i[WORD_W-2:0], 1'b1};
        prod_w = x_i * odd_w;
        y_o    = {prod_w[WORD_W-LG_W-1:0], prod_w[WORD_W-1:WORD_W-LG_W]};
    end
endmodule

// File: rtl/rc6_xor_rot_add.sv
// y = rotl(a xor m, sh) + k, all modulo 2^W
module rc6_xor_rot_add #(
    parameter int WORD_W = 32,
    parameter int LG_W   = 5
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] m_i,
    input  logic [LG_W-1:0]   sh_i,
    input  logic [WORD_W-1:0] k_i,
    output logic [WORD_W-1:0] y_o
);
    logic [WORD_W-1:0]   mixed_w;
    logic [2*WORD_W-1:0] dbl_w;

    always_comb begin
        mixed_w = a_i ^ m_i;
        dbl_w   = {mixed_w, mixed_w} << sh_i;
        y_o     = dbl_w[2*WORD_W-1:WORD_W] + k_i;
    end
endmodule

// File: rtl/rc6_enc_core.sv
module rc6_enc_core #(
    parameter int WORD_W = 32,
    parameter int ROUNDS = 20,
    localparam int LG_W   = $clog2(WORD_W),
    localparam int BLK_W  = 4 * WORD_W,
    localparam int NPAIR  = ROUNDS + 2,
    localparam int IDX_W  = $clog2(NPAIR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [BLK_W-1:0]    block_in,
    output logic [IDX_W-1:0]    key_idx,
    input  logic [2*WORD_W-1:0] key_pair,
    output logic [BLK_W-1:0]    result,
    output logic                done
);
    import rc6_pkg::*;

    localparam int RND_W = $clog2(ROUNDS + 1);
    localparam int LAT_W = $clog2(2 * ROUNDS + 2) + 1;

    typedef struct packed {
        rc6_state_e        state;
        logic [RND_W-1:0]  round;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] c;
        logic [WORD_W-1:0] d;
        logic [WORD_W-1:0] t;
        logic [WORD_W-1:0] u;
        logic              done;
    } core_s;

    core_s core_d, core_q;

    logic [WORD_W-1:0] k_lo, k_hi;
    assign k_lo = key_pair[WORD_W-1:0];
    assign k_hi = key_pair[2*WORD_W-1:WORD_W];

    // Two quadratic mixers: lane 0 on B, lane 1 on D
    logic [WORD_W-1:0] mix_src [2];
    logic [WORD_W-1:0] mix_res [2];
    assign mix_src[0] = core_q.b;
    assign mix_src[1] = core_q.d;

    // Two xor-rotate-add lanes: lane 0 updates A, lane 1 updates C
    logic [WORD_W-1:0] upd_a   [2];
    logic [WORD_W-1:0] upd_m   [2];
    logic [LG_W-1:0]   upd_sh  [2];
    logic [WORD_W-1:0] upd_k   [2];
    logic [WORD_W-1:0] upd_res [2];
    assign upd_a[0]  = core_q.a;
    assign upd_m[0]  = core_q.t;
    assign upd_sh[0] = core_q.u[LG_W-1:0];
    assign upd_k[0]  = k_lo;
    assign upd_a[1]  = core_q.c;
    assign upd_m[1]  = core_q.u;
    assign upd_sh[1] = core_q.t[LG_W-1:0];
    assign upd_k[1]  = k_hi;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        rc6_quad_mix #(.WORD_W(WORD_W), .LG_W(LG_W)) u_mix (
            .x_i (mix_src[g]),
            .y_o (mix_res[g])
        );
        rc6_xor_rot_add #(.WORD_W(WORD_W), .LG_W(LG_W)) u_upd (
            .a_i  (upd_a[g]),
            .m_i  (upd_m[g]),
            .sh_i (upd_sh[g]),
            .k_i  (upd_k[g]),
            .y_o  (upd_res[g])
        );
    end

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        case (core_q.state)
            ST_IDLE: begin
                if (start) begin
                    core_d.a     = block_in[WORD_W-1:0];
                    core_d.b     = block_in[2*WORD_W-1:WORD_W] + k_lo;
                    core_d.c     = block_in[3*WORD_W-1:2*WORD_W];
                    core_d.d     = block_in[4*WORD_W-1:3*WORD_W] + k_hi;
                    core_d.round = RND_W'(1);
                    core_d.state = ST_MIX;
                end
            end
            ST_MIX: begin
                core_d.t     = mix_res[0];
                core_d.u     = mix_res[1];
                core_d.state = ST_ROT;
            end
            ST_ROT: begin
                core_d.a = core_q.b;
                core_d.b = upd_res[1];
                core_d.c = core_q.d;
                core_d.d = upd_res[0];
                if (core_q.round == RND_W'(ROUNDS)) begin
                    core_d.state = ST_FIN;
                end else begin
                    core_d.round = core_q.round + RND_W'(1);
                    core_d.state = ST_MIX;
                end
            end
            default: begin
                core_d.a     = core_q.a + k_lo;
                core_d.c     = core_q.c + k_hi;
                core_d.done  = 1'b1;
                core_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    always_comb begin
        case (core_q.state)
            ST_IDLE: key_idx = '0;
            ST_FIN:  key_idx = IDX_W'(NPAIR - 1);
            default: key_idx = IDX_W'(core_q.round);
        endcase
    end

    assign result = {core_q.d, core_q.c, core_q.b, core_q.a};
    assign done   = core_q.done;

    // Cycle counter used only by the latency check below
    logic [LAT_W-1:0] lat_d, lat_q;
    always_comb begin
        lat_d = lat_q;
        if (core_q.state == ST_IDLE) begin
            if (start) lat_d = '0;
        end else begin
            lat_d = lat_q + LAT_W'(1);
        end
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    a_r8_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lat_q == LAT_W'(2 * ROUNDS + 1));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_prewhite_d: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_IDLE && start) |=>
        result[4*WORD_W-1:3*WORD_W] ==
            $past(block_in[4*WORD_W-1:3*WORD_W]) + $past(key_pair[2*WORD_W-1:WORD_W]));

    a_r2_load_a: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_IDLE && start) |=>
        result[WORD_W-1:0] == $past(block_in[WORD_W-1:0]));

    a_r5_mix_to_rot: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.state == ST_MIX |=> core_q.state == ST_ROT && $stable(key_idx));

    a_r9_busy_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_MIX || core_q.state == ST_ROT) |=> core_q.state != ST_IDLE);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.state == ST_IDLE && !start) |=> $stable(result));

    a_r7_post_keeps_b: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.state == ST_FIN |=> $stable(result[2*WORD_W-1:WORD_W]) && done);

    a_r11_fin_index: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.state == ST_FIN |-> key_idx == IDX_W'(NPAIR - 1));
endmodule

// File: tb/rc6_enc_core_tb_top.sv
module rc6_enc_core_tb_top;
    localparam int W  = 32;
    localparam int R  = 20;
    localparam int NP = R + 2;
    localparam int IW = $clog2(NP);
    localparam int LAST = 2 * R + 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          start;
    logic [127:0]  block_in;
    logic [IW-1:0] key_idx;
    logic [63:0]   key_pair;
    logic [127:0]  result;
    logic          done;

    logic [31:0] sk [2*NP];
    int n_run  = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;

    rc6_enc_core dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .block_in (block_in),
        .key_idx  (key_idx),
        .key_pair (key_pair),
        .result   (result),
        .done     (done)
    );

    // R3: external key table, same-cycle pair lookup
    always_comb begin
        int j;
        j = int'(key_idx);
        if (j < NP) key_pair = {sk[2*j+1], sk[2*j]};
        else        key_pair = '0;
    end

    function automatic logic [31:0] rl(input logic [31:0] x, input int s);
        return (x << s) | (x >> (32 - s));
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] p);
        logic [31:0] a, b, c, d, t, u, tmp;
        a = p[31:0]; b = p[63:32]; c = p[95:64]; d = p[127:96];
        b = b + sk[0];
        d = d + sk[1];
        for (int i = 1; i <= R; i++) begin
            t = rl(b * (2 * b + 32'd1), 5);
            u = rl(d * (2 * d + 32'd1), 5);
            a = rl(a ^ t, int'(u[4:0])) + sk[2*i];
            c = rl(c ^ u, int'(t[4:0])) + sk[2*i+1];
            tmp = a; a = b; b = c; c = d; d = tmp;
        end
        a = a + sk[2*R+2];
        c = c + sk[2*R+3];
        return {d, c, b, a};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural cycle model: edges since the accepted start, -1 when idle
    int cyc_n = -1;
    always @(posedge clk) begin
        if (!rst_n)                          cyc_n <= -1;
        else if (cyc_n == -1 || cyc_n == LAST) cyc_n <= start ? 0 : -1;
        else                                 cyc_n <= cyc_n + 1;
    end

    // R8 R11 R3: compare index and done against the model every cycle
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            int exp_idx;
            exp_idx = (cyc_n >= 0 && cyc_n <= 2 * R) ? cyc_n / 2 + 1 : 0;
            chk("R11 key index", 128'(key_idx), 128'(exp_idx));
            chk("R8 done timing", 128'(done), 128'(cyc_n == LAST));
        end
    end

    task automatic fill_keys();
        for (int i = 0; i < 2 * NP; i++) sk[i] = $urandom;
    endtask

    task automatic encrypt(input logic [127:0] p, output logic [127:0] c, output int lat);
        @(negedge clk);
        block_in = p;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        block_in = ~p;
        lat = 1;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
        c = result;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] p, c1, c2;
        int lat;
        rst_n    = 1'b0;
        start    = 1'b0;
        block_in = '0;
        for (int i = 0; i < 2 * NP; i++) sk[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", 128'(done), 128'(0));
        chk("R1 key_idx", 128'(key_idx), 128'(0));
        chk("R1 result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        // All-zero table and plaintext stay zero
        encrypt('0, c1, lat);
        chk("R4 R5 R6 zero data", c1, '0);

        // R2 R3 R4 R5 R6 R7: random tables and patterns
        fill_keys();
        encrypt('0, c1, lat);
        chk("R2 R3 R5 R6 zero plaintext", c1, ref_enc('0));
        encrypt('1, c1, lat);
        chk("R2 R3 R5 R6 ones plaintext", c1, ref_enc('1));
        encrypt(128'h000102030405060708090a0b0c0d0e0f, c1, lat);
        chk("R2 byte ramp", c1, ref_enc(128'h000102030405060708090a0b0c0d0e0f));
        for (int k = 0; k < 4; k++) begin
            fill_keys();
            p = {$urandom, $urandom, $urandom, $urandom};
            encrypt(p, c1, lat);
            chk("R4 R5 R6 R7 random block", c1, ref_enc(p));
        end

        // R8: start cycle to done cycle is 42
        chk("R8 latency", 128'(lat), 128'(LAST + 1));

        // R7: only A and C take the final key pair
        p = {$urandom, $urandom, $urandom, $urandom};
        encrypt(p, c1, lat);
        sk[2*R+2] = sk[2*R+2] + 32'd1;
        sk[2*R+3] = sk[2*R+3] + 32'd5;
        encrypt(p, c2, lat);
        chk("R7 word A", 128'(c2[31:0]), 128'(c1[31:0] + 32'd1));
        chk("R7 word C", 128'(c2[95:64]), 128'(c1[95:64] + 32'd5));
        chk("R7 words B D", {c2[127:96], c2[63:32]}, {c1[127:96], c1[63:32]});

        // R9: start while busy is ignored
        fill_keys();
        p = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        block_in = p;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        repeat (9) @(negedge clk);
        block_in = ~p;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        while (!done) @(negedge clk);
        chk("R9 busy start ignored", result, ref_enc(p));
        c1 = result;

        // R10: idle result holds while block_in moves
        for (int k = 0; k < 10; k++) begin
            block_in = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
        end
        chk("R10 idle hold", result, c1);

        // Back-to-back: start in the same cycle done is shown
        p = {$urandom, $urandom, $urandom, $urandom};
        encrypt(p, c1, lat);
        block_in = ~p;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        while (!done) @(negedge clk);
        chk("R8 R9 back-to-back", result, ref_enc(~p));

        repeat (3) @(negedge clk);
        mon_en = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule